// File: doc/BRIEF.md
# Recency-coded pixel stream packer

This block compresses a raster stream of 12-bit colour pixels (4 bits each of red, green and blue) into a dense bitstream of variable-length codes, and hands that stream out as bytes to a downstream packet framer. Most screens hold large flat areas and only a few colours, so the block keeps a short most-recently-used colour list and counts repeats within a raster line. A pixel then costs a single bit, a short index, one share of a 16-bit run token, or a 17-bit literal.

The upstream video source raises a strobe one cycle before the matching pixel value reaches the pins. The block therefore delays the strobe internally by one register, so strobe and data line up. Codes enter a 32-bit accumulator. Whole bytes leave it most significant bit first through a valid/ready pair. The bitstream never restarts at packet edges. Only a frame-start pulse realigns it to a byte boundary and resets the colour history. Frame start must be given between lines, once the pixel path has drained.

Top module: `pix_pack_enc`

## Requirements
- R1: A strobe on `pix_stb` in a cycle where `pix_ready` is high accepts one pixel, whose colour and end-of-line flag are taken from `pix_rgb`/`pix_eol` in the following cycle; the values on those pins in the strobe cycle itself are ignored.
- R2: A single pixel equal to the previous pixel (recency slot 0), and not followed by a further equal pixel before the run ends, is coded as the one bit `0`.
- R3: A pixel equal to recency slot 1 is coded as `10`.
- R4: A pixel equal to recency slot 2, 3 or 4 is coded as `1100`, `1101` or `1110` respectively; when several slots hold the colour, the lowest-numbered slot is used.
- R5: A pixel found in no slot is coded as `11111` followed by its 12-bit value, red nibble first.
- R6: A hit at slot k moves that colour to slot 0 and moves slots 0..k-1 one place down; a literal enters slot 0 and the colour in slot 4 is dropped.
- R7: Consecutive repeats of the slot-0 colour are counted; a count of two or more is sent as `11110000` followed by the 8-bit count, emitted when a different colour arrives, when the count reaches 255, or on the end-of-line pixel.
- R8: A run never spans two lines: the end-of-line pixel closes any open count, and repeats on the next line begin a new count.
- R9: A frame-start pulse sets all five slots to black (0x000), and pads any partial byte in the accumulator with zero bits so that it is released.
- R10: Output bytes carry the bitstream most significant bit first; `out_data` holds steady while `out_valid` is high and `out_ready` is low, and no byte is lost or repeated under backpressure.
- R11: `pix_ready` is low whenever the accumulator has fewer than 17 free bits, or two accepted pixels are still waiting to be coded.
- R12: After reset no byte is offered, `pix_ready` is high, and all recency slots hold black.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Clears colour history and byte-aligns the bitstream |
| pix_stb | input | 1 | Pixel strobe, one cycle ahead of the pixel value |
| pix_ready | output | 1 | High when a strobe in this cycle is accepted |
| pix_rgb | input | 12 | Pixel colour, red in bits 11:8, blue in bits 3:0 |
| pix_eol | input | 1 | Marks the last pixel of a raster line, with the pixel value |
| out_data | output | 8 | Packed output byte |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
Several properties are checked on every cycle: the run counter never holds the flush limit, a literal always lands in slot 0, frame start empties the history, the accumulator never overfills, the input buffer never overflows, and a stalled output byte does not change. Whether the bytes are correct can only be shown by the bench scenarios. These cover the choice among repeat, index, run and literal codes, move-to-front order and eviction, run splitting at 255 and at line ends, strobe-to-data alignment, and padding on frame start. All of this is compared against an independent model of the code under random-free but uneven output backpressure.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;
  localparam int COLOR_W = 12;
  localparam int SLOTS   = 5;
  localparam int RUN_W   = 8;
  localparam int RUN_MAX = (1 << RUN_W) - 1;
  localparam int ACC_W   = 32;
  localparam int BYTE_W  = 8;
  localparam int CODE_W  = 5 + COLOR_W;
  localparam int LEN_W   = $clog2(CODE_W + 1);
  localparam int CNT_W   = $clog2(ACC_W + 8);
  localparam int HIT_W   = $clog2(SLOTS + 1);
  localparam logic [7:0] RUN_HDR = 8'hF0;

  typedef logic [COLOR_W-1:0] rgb_t;

  typedef struct packed {
    logic eol;
    rgb_t rgb;
  } px_t;
endpackage

// File: rtl/pix_in_buf.sv
module pix_in_buf
  import pix_pack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pix_stb,
  input  rgb_t pix_rgb,
  input  logic pix_eol,
  input  logic pop,
  input  logic room,
  output logic pix_ready,
  output logic head_valid,
  output px_t  head
);
  logic       stb_q;
  logic [1:0] cnt_q, cnt_d;
  px_t        ent_q [2];
  px_t        ent_d [2];
  px_t        in_px;

  assign in_px      = '{eol: pix_eol, rgb: pix_rgb};
  assign head_valid = (cnt_q != 2'd0);
  assign head       = ent_q[0];
  assign pix_ready  = rst_n && room && (({1'b0, cnt_q} + {2'b0, stb_q}) <= 3'd1);

  always_comb begin
    ent_d = ent_q;
    cnt_d = cnt_q;
    unique case ({stb_q, pop})
      2'b10: begin
        if (cnt_q == 2'd0) ent_d[0] = in_px;
        else               ent_d[1] = in_px;
        cnt_d = cnt_q + 2'd1;
      end
      2'b01: begin
        ent_d[0] = ent_q[1];
        cnt_d    = cnt_q - 2'd1;
      end
      2'b11: begin
        if (cnt_q == 2'd1) ent_d[0] = in_px;
        else begin
          ent_d[0] = ent_q[1];
          ent_d[1] = in_px;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q    <= 1'b0;
      cnt_q    <= 2'd0;
      ent_q[0] <= '0;
      ent_q[1] <= '0;
    end else begin
      stb_q <= pix_stb && pix_ready;
      cnt_q <= cnt_d;
      if (stb_q || pop) begin
        ent_q[0] <= ent_d[0];
        ent_q[1] <= ent_d[1];
      end
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (cnt_q < 2'd2 || pop));

  assert_pop_needs_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);
endmodule

// File: rtl/pix_code_sel.sv
module pix_code_sel
  import pix_pack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              head_valid,
  input  px_t               head,
  input  logic              room,
  output logic              pop,
  output logic              emit,
  output logic [CODE_W-1:0] code,
  output logic [LEN_W-1:0]  len
);
  rgb_t             rec_q [SLOTS];
  rgb_t             rec_d [SLOTS];
  logic [RUN_W-1:0] pend_q, pend_d;
  logic [SLOTS-1:0] match;
  logic [HIT_W-1:0] hit;
  logic [RUN_W:0]   run_next;

  for (genvar g = 0; g < SLOTS; g++) begin : g_match
    assign match[g] = (rec_q[g] == head.rgb);
  end

  always_comb begin
    hit = HIT_W'(SLOTS);
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (match[i]) hit = HIT_W'(i);
    end
  end

  assign run_next = {1'b0, pend_q} + {{RUN_W{1'b0}}, 1'b1};

  always_comb begin
    pop    = 1'b0;
    emit   = 1'b0;
    code   = '0;
    len    = '0;
    rec_d  = rec_q;
    pend_d = pend_q;
    if (frame_start) begin
      for (int i = 0; i < SLOTS; i++) rec_d[i] = '0;
      pend_d = '0;
    end else if (head_valid && room) begin
      if (hit == '0) begin
        pop = 1'b1;
        if (run_next == (RUN_W + 1)'(RUN_MAX) || head.eol) begin
          emit   = 1'b1;
          pend_d = '0;
          if (run_next == (RUN_W + 1)'(1)) begin
            len = LEN_W'(1);
          end else begin
            code = {RUN_HDR, run_next[RUN_W-1:0], 1'b0};
            len  = LEN_W'(16);
          end
        end else begin
          pend_d = run_next[RUN_W-1:0];
        end
      end else if (pend_q != '0) begin
        emit   = 1'b1;
        pend_d = '0;
        if (pend_q == RUN_W'(1)) begin
          len = LEN_W'(1);
        end else begin
          code = {RUN_HDR, pend_q, 1'b0};
          len  = LEN_W'(16);
        end
      end else begin
        pop  = 1'b1;
        emit = 1'b1;
        unique case (hit)
          HIT_W'(1): begin code = {2'b10,   {(CODE_W-2){1'b0}}}; len = LEN_W'(2); end
          HIT_W'(2): begin code = {4'b1100, {(CODE_W-4){1'b0}}}; len = LEN_W'(4); end
          HIT_W'(3): begin code = {4'b1101, {(CODE_W-4){1'b0}}}; len = LEN_W'(4); end
          HIT_W'(4): begin code = {4'b1110, {(CODE_W-4){1'b0}}}; len = LEN_W'(4); end
          default:   begin code = {5'b11111, head.rgb};          len = LEN_W'(CODE_W); end
        endcase
        rec_d[0] = head.rgb;
        for (int i = 1; i < SLOTS; i++) begin
          if (HIT_W'(i) <= hit) rec_d[i] = rec_q[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) rec_q[i] <= '0;
      pend_q <= '0;
    end else begin
      if (frame_start || (head_valid && room)) begin
        rec_q  <= rec_d;
        pend_q <= pend_d;
      end
    end
  end

  assert_run_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q != RUN_W'(RUN_MAX));

  assert_literal_front_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && pop && len == LEN_W'(CODE_W)) |=> rec_q[0] == $past(head.rgb));

  assert_frame_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (rec_q[SLOTS-1] == '0 && rec_q[1] == '0 && pend_q == '0));
endmodule

// File: rtl/pix_bit_packer.sv
module pix_bit_packer
  import pix_pack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic [CODE_W-1:0] code,
  input  logic [LEN_W-1:0]  len,
  input  logic              pad,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  output logic              room
);
  logic [ACC_W-1:0] acc_q, acc_d, base, wide;
  logic [CNT_W-1:0] cnt_q, cnt_d, bcnt, sum;
  logic             fire;

  assign wide      = {code, {(ACC_W-CODE_W){1'b0}}};
  assign out_valid = (cnt_q >= CNT_W'(BYTE_W));
  assign out_data  = acc_q[ACC_W-1 -: BYTE_W];
  assign room      = (cnt_q <= CNT_W'(ACC_W - CODE_W));
  assign fire      = out_valid && out_ready;

  always_comb begin
    base = fire ? (acc_q << BYTE_W) : acc_q;
    bcnt = fire ? (cnt_q - CNT_W'(BYTE_W)) : cnt_q;
    sum  = bcnt + CNT_W'(7);
    acc_d = base;
    cnt_d = bcnt;
    if (emit) begin
      acc_d = base | (wide >> bcnt);
      cnt_d = bcnt + CNT_W'(len);
    end else if (pad) begin
      cnt_d = {sum[CNT_W-1:3], 3'b000};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      if (emit || pad || fire) begin
        acc_q <= acc_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> ({1'b0, cnt_q} + (CNT_W + 1)'(len) <= (CNT_W + 1)'(ACC_W)));

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/pix_pack_enc.sv
module pix_pack_enc
  import pix_pack_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               pix_stb,
  output logic               pix_ready,
  input  logic [COLOR_W-1:0] pix_rgb,
  input  logic               pix_eol,
  output logic [BYTE_W-1:0]  out_data,
  output logic               out_valid,
  input  logic               out_ready
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              head_valid, pop, emit, room;
  px_t               head;
  logic [CODE_W-1:0] code;
  logic [LEN_W-1:0]  len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  pix_in_buf u_buf (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .pix_stb    (pix_stb),
    .pix_rgb    (pix_rgb),
    .pix_eol    (pix_eol),
    .pop        (pop),
    .room       (room),
    .pix_ready  (pix_ready),
    .head_valid (head_valid),
    .head       (head)
  );

  pix_code_sel u_sel (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .frame_start (frame_start),
    .head_valid  (head_valid),
    .head        (head),
    .room        (room),
    .pop         (pop),
    .emit        (emit),
    .code        (code),
    .len         (len)
  );

  pix_bit_packer u_pack (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .emit      (emit),
    .code      (code),
    .len       (len),
    .pad       (frame_start),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .room      (room)
  );
endmodule

// File: tb/sim_pix_pack_enc.sv
`timescale 1ns/1ps
module sim_pix_pack_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        pix_stb = 1'b0;
  logic        pix_ready;
  logic [11:0] pix_rgb = 12'h000;
  logic        pix_eol = 1'b0;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;

  always #2 clk = ~clk;

  pix_pack_enc u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pix_stb(pix_stb), .pix_ready(pix_ready), .pix_rgb(pix_rgb), .pix_eol(pix_eol),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;
  string       cur_req = "R12";
  int          bp_mode = 0;
  int          cyc = 0;
  logic [7:0]  exp_q [$];
  bit          bq [$];
  logic [11:0] mrec [5];
  int          mpend = 0;
  bit          pend_v = 1'b0;
  logic [11:0] pend_rgb = 12'h000;
  bit          pend_eol = 1'b0;

  task automatic check(string req, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model of the code, written from the requirements
  task automatic put_bits(logic [16:0] v, int n);
    for (int i = n - 1; i >= 0; i--) bq.push_back(v[i]);
    while (bq.size() >= 8) begin
      logic [7:0] b;
      for (int k = 0; k < 8; k++) b[7-k] = bq.pop_front();
      exp_q.push_back(b);
    end
  endtask

  task automatic flush_run();
    if (mpend == 1) put_bits(17'd0, 1);
    else if (mpend >= 2) put_bits({1'b0, 8'hF0, 8'(mpend)}, 16);
    mpend = 0;
  endtask

  task automatic model_px(logic [11:0] p, bit e);
    if (p == mrec[0]) begin
      mpend++;
      if (mpend == 255 || e) flush_run();
    end else begin
      int idx = 5;
      flush_run();
      for (int j = 4; j >= 1; j--) if (mrec[j] == p) idx = j;
      case (idx)
        1: put_bits(17'b10, 2);
        2: put_bits(17'b1100, 4);
        3: put_bits(17'b1101, 4);
        4: put_bits(17'b1110, 4);
        default: put_bits({5'b11111, p}, 17);
      endcase
      if (idx == 5) idx = 4;
      for (int j = idx; j >= 1; j--) mrec[j] = mrec[j-1];
      mrec[0] = p;
    end
  endtask

  task automatic model_frame();
    for (int j = 0; j < 5; j++) mrec[j] = 12'h000;
    mpend = 0;
    while (bq.size() % 8 != 0) bq.push_back(1'b0);
    put_bits(17'd0, 0);
  endtask

  // driver: strobe one cycle ahead of the value (R1)
  task automatic drive_pending();
    if (pend_v) begin
      pix_rgb = pend_rgb;
      pix_eol = pend_eol;
    end else begin
      pix_rgb = 12'hA5A ^ 12'(cyc);
      pix_eol = cyc[0];
    end
    pend_v = 1'b0;
  endtask

  task automatic send_px(logic [11:0] p, bit e);
    model_px(p, e);
    forever begin
      @(negedge clk);
      drive_pending();
      if (pix_ready) begin
        pix_stb  = 1'b1;
        pend_v   = 1'b1;
        pend_rgb = p;
        pend_eol = e;
        break;
      end
      pix_stb = 1'b0;
    end
  endtask

  task automatic flush_drv();
    @(negedge clk);
    drive_pending();
    pix_stb = 1'b0;
  endtask

  task automatic idle(int n);
    int saved = bp_mode;
    flush_drv();
    bp_mode = 0;
    repeat (n) @(negedge clk);
    bp_mode = saved;
  endtask

  task automatic new_frame();
    idle(64);
    @(negedge clk);
    frame_start = 1'b1;
    model_frame();
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected bytes and compares as the design hands them out
  initial begin
    forever begin
      @(negedge clk);
      case (bp_mode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3 != 0);
        default: out_ready = 1'b0;
      endcase
      #0.5;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R10", 1'b0, int'(out_data), -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(cur_req, out_data == e, int'(out_data), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 5; j++) mrec[j] = 12'h000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state, black history means a black pixel is a repeat
    cur_req = "R12";
    check("R12", out_valid == 1'b0, int'(out_valid), 0);
    check("R12", pix_ready == 1'b1, int'(pix_ready), 1);
    send_px(12'h000, 1'b1);

    // R5 and R1: literals, garbage on the pins in every strobe cycle
    cur_req = "R5";
    send_px(12'h123, 1'b0);
    send_px(12'hFED, 1'b0);
    send_px(12'h808, 1'b1);

    // R3: two colours alternating
    cur_req = "R3";
    for (int i = 0; i < 12; i++) send_px(i[0] ? 12'h0F0 : 12'h00F, i == 11);

    // R4 and R6: fill all slots, then hit deeper slots and move to front
    cur_req = "R4";
    for (int i = 1; i <= 5; i++) send_px(12'h100 * i[11:0] + 12'h011, 1'b0);
    send_px(12'h311, 1'b0);
    send_px(12'h111, 1'b0);
    send_px(12'h411, 1'b0);
    send_px(12'h211, 1'b1);

    // R6: eviction of the oldest colour
    cur_req = "R6";
    for (int i = 0; i < 6; i++) send_px(12'hC00 + 12'(i), 1'b0);
    send_px(12'hC00, 1'b1);

    // R7: long run split at 255, short runs of two and one
    cur_req = "R7";
    for (int i = 0; i < 300; i++) send_px(12'h5A5, i == 299);
    send_px(12'h777, 1'b0);
    send_px(12'h777, 1'b0);
    send_px(12'h777, 1'b0);
    send_px(12'h333, 1'b0);
    send_px(12'h333, 1'b0);
    send_px(12'h777, 1'b1);

    // R2: single repeats between colour changes
    cur_req = "R2";
    for (int i = 0; i < 8; i++) begin
      send_px(12'hABC, 1'b0);
      send_px(12'hABC, 1'b0);
      send_px(12'h0C0, i == 7);
    end

    // R8: runs stop at the line end
    cur_req = "R8";
    send_px(12'h246, 1'b0);
    send_px(12'h246, 1'b0);
    send_px(12'h246, 1'b1);
    send_px(12'h246, 1'b0);
    send_px(12'h246, 1'b0);
    send_px(12'h135, 1'b1);

    // R10: uneven output backpressure over mixed content
    cur_req = "R10";
    bp_mode = 1;
    for (int i = 0; i < 60; i++) send_px((i % 7 < 3) ? 12'h9E9 : 12'h100 + 12'(i % 5), i % 20 == 19);
    bp_mode = 0;

    // R11: accumulator full stalls the pixel input
    idle(64);
    cur_req = "R11";
    bp_mode = 2;
    send_px(12'hE01, 1'b0);
    send_px(12'hE02, 1'b1);
    flush_drv();
    repeat (6) @(negedge clk);
    check("R11", pix_ready == 1'b0, int'(pix_ready), 0);
    check("R11", out_valid == 1'b1, int'(out_valid), 1);
    bp_mode = 0;

    // R9: padding and history clear at frame start
    cur_req = "R9";
    send_px(12'h0AB, 1'b1);
    new_frame();
    send_px(12'h000, 1'b0);
    send_px(12'h0AB, 1'b0);
    send_px(12'h000, 1'b1);
    new_frame();
    idle(64);
    check("R10", exp_q.size() == 0, exp_q.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule